// File: doc/BRIEF.md
# Cache Flush Sequencer

This block sits in a processor's bus interface and carries out a full cache flush on request. An external flush pulse is recorded while the block is idle and is taken at the next instruction boundary. Two core-issued commands can also start it: a software writeback-with-invalidate and an invalidate-only. After it accepts a command, the block asks the core to empty its pipeline. It then steps through every data-cache line and writes back the modified ones as four-beat bursts. After the writebacks it wipes every valid bit in one cycle. It ends by placing a coded special cycle on the bus.

The caches are held as small register files. Lines are loaded through a fill stream. That stream is valid/ready: `fill_ready` is high only while the block is idle. A fill offered while the block is busy is not taken, and the source has to hold it until ready returns. The bus side is simple. A cycle is live while `bus_cyc` is high, and each `bus_brdy` completes one beat. Three inputs control bus ownership. `bus_backoff` aborts the cycle in flight. `bus_ahold` stops a new cycle from starting. `bus_hold` is granted through `bus_hlda`, and only between cycles.

Top module: `flush_seq`

## Requirements
- R1: A command is accepted only in a cycle with `insn_boundary` high while idle. A `flush_req` pulse seen while idle is kept pending until a boundary arrives. In the cycle after acceptance, `pipe_flush` is high for exactly one cycle and `busy` rises.
- R2: A `flush_req` pulse that arrives while `busy` is dropped. No second sequence follows, even with `insn_boundary` held high afterwards.
- R3: Priority at a boundary is flush, then software writeback-invalidate, then invalidate-only, then the management interrupt. `smi_ack` is high only when `smi_req` is present and no command is being accepted.
- R4: The data lines are visited in ascending index order. Lines that are clean or invalid are skipped without any bus activity. Each valid modified line is written back as one burst of BEATS beats. Each beat carries address `{index, beat}` in `bus_addr`, with `bus_be`=8'hFF, `bus_dc`=1, `bus_mio`=1 and `bus_wr`=1.
- R5: During writebacks, no valid bit changes. After the last writeback, the linear and physical valid vectors of both caches clear together in a single cycle.
- R6: A flush ends with a special cycle carrying `bus_dc`=0, `bus_mio`=0, `bus_wr`=1, `bus_be`=8'hEF and `bus_addr`=0. This cycle stays on the bus until `bus_brdy`, and `done` comes only after it.
- R7: `bus_backoff` during a writeback ends that cycle on the next edge. The same line is then reissued from beat 0 once backoff is low.
- R8: No bus cycle begins in the cycle after `bus_ahold`, `bus_hold` or `bus_backoff` was high. `bus_hlda` is never high while a cycle is live.
- R9: A software writeback-invalidate runs the same steps as a flush, but its closing special cycle carries `bus_be`=8'hF7.
- R10: An invalidate-only command clears every valid bit with no bus cycle at all, dirty lines included.
- R11: Reset, including a reset in the middle of a sequence, clears all valid and dirty bits and leaves the block idle with no bus cycle.
- R12: `done` is a single-cycle pulse. `busy` is low in the cycle after `done`.
- R13: `fill_ready` is high exactly when the block is idle. A handshake sets the addressed line's linear and physical valid bits. For the data cache (`fill_icache`=0) it also loads the dirty bit from `fill_dirty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_boundary | input | 1 | Core is between instructions |
| flush_req | input | 1 | External flush request pulse |
| wbinvd_req | input | 1 | Software writeback-invalidate strobe |
| invd_req | input | 1 | Invalidate-only strobe |
| smi_req | input | 1 | Pending management interrupt (level) |
| smi_ack | output | 1 | Interrupt taken this cycle |
| pipe_flush | output | 1 | Pipeline drain request, one cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, one cycle |
| fill_valid | input | 1 | Fill stream valid |
| fill_ready | output | 1 | Fill stream ready |
| fill_icache | input | 1 | Fill targets instruction cache |
| fill_idx | input | IDX_W | Line index of fill |
| fill_dirty | input | 1 | Fill marks data line modified |
| dval_lin | output | LINES | Data linear-tag valid bits |
| dval_phys | output | LINES | Data physical-tag valid bits |
| ival_lin | output | LINES | Instruction linear-tag valid bits |
| ival_phys | output | LINES | Instruction physical-tag valid bits |
| bus_cyc | output | 1 | Bus cycle live |
| bus_addr | output | ADDR_W | Address bits 31..3 |
| bus_be | output | 8 | Byte enables |
| bus_dc | output | 1 | Data/code qualifier |
| bus_mio | output | 1 | Memory/IO qualifier |
| bus_wr | output | 1 | Write/read qualifier |
| bus_brdy | input | 1 | Beat ready |
| bus_backoff | input | 1 | Abort current cycle |
| bus_ahold | input | 1 | Address hold, block new cycles |
| bus_hold | input | 1 | Bus hold request |
| bus_hlda | output | 1 | Bus hold granted |

## Verification
The bench runs writebacks against several masks of dirty lines: none, the two end indices, scattered lines, and every line. A design that scanned the lines out of order, or that spent bus cycles on clean lines, would put the wrong address on some beat. Backoff is raised before the first beat and also in the middle of a burst. A design that resumed at the aborted beat, or that moved on to the next line, would fail the address check on the reissued burst. Hold and address hold are applied while the sequence runs, and the bench checks that no cycle begins while they are high and that the grant never overlaps a live cycle. Other directed cases cover the following:
- a flush pulse away from an instruction boundary;
- a second pulse while the block is busy;
- a flush competing with a pending interrupt;
- a delayed ready on the acknowledge cycle;
- a reset in the middle of a sequence.

Each of these would expose a block that acted at the wrong time, ran twice, or dropped the acknowledge early.

// File: rtl/flush_pkg.sv
package flush_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PIPE, S_SCAN, S_WB, S_INVAL, S_ACK, S_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    K_FLUSH, K_WBINVD, K_INVD
  } flush_kind_t;

  localparam logic [7:0] BE_FLUSH_ACK = 8'hEF;
  localparam logic [7:0] BE_WB_ACK    = 8'hF7;
  localparam logic [7:0] BE_LINE      = 8'hFF;
endpackage

// File: rtl/flush_req_arb.sv
module flush_req_arb
  import flush_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        idle,
  input  logic        insn_boundary,
  input  logic        flush_req,
  input  logic        wbinvd_req,
  input  logic        invd_req,
  input  logic        smi_req,
  output logic        start,
  output flush_kind_t kind,
  output logic        smi_ack
);
  logic pend;
  logic fl_any;

  assign fl_any = flush_req | pend;

  always_comb begin
    start   = 1'b0;
    kind    = K_FLUSH;
    smi_ack = 1'b0;
    if (idle && insn_boundary) begin
      if (fl_any) begin
        start = 1'b1;
      end else if (wbinvd_req) begin
        start = 1'b1;
        kind  = K_WBINVD;
      end else if (invd_req) begin
        start = 1'b1;
        kind  = K_INVD;
      end else if (smi_req) begin
        smi_ack = 1'b1;
      end
    end
  end

  // Pending flush is only recorded while idle; a busy block drops it (R2).
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= idle && fl_any && !insn_boundary;
  end

  a_r2_no_pend_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle) |=> !pend);
endmodule

// File: rtl/flush_tag_store.sv
module flush_tag_store #(
  parameter int LINES = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic             fill_icache,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_dirty,
  input  logic             inval_all,
  input  logic             clean_en,
  input  logic [IDX_W-1:0] clean_idx,
  output logic [LINES-1:0] dval_lin,
  output logic [LINES-1:0] dval_phys,
  output logic [LINES-1:0] ival_lin,
  output logic [LINES-1:0] ival_phys,
  output logic [LINES-1:0] dirty
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit_fill;
    logic hit_clean;
    assign hit_fill  = fill_en && (fill_idx == IDX_W'(g));
    assign hit_clean = clean_en && (clean_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n || inval_all) begin
        dval_lin[g]  <= 1'b0;
        dval_phys[g] <= 1'b0;
        ival_lin[g]  <= 1'b0;
        ival_phys[g] <= 1'b0;
        dirty[g]     <= 1'b0;
      end else begin
        if (hit_fill && fill_icache) begin
          ival_lin[g]  <= 1'b1;
          ival_phys[g] <= 1'b1;
        end
        if (hit_fill && !fill_icache) begin
          dval_lin[g]  <= 1'b1;
          dval_phys[g] <= 1'b1;
          dirty[g]     <= fill_dirty;
        end else if (hit_clean) begin
          dirty[g] <= 1'b0;
        end
      end
    end
  end

  a_r5_clear_together: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> ((dval_lin | dval_phys | ival_lin | ival_phys | dirty) == '0));
endmodule

// File: rtl/flush_bus_engine.sv
module flush_bus_engine #(
  parameter int BEATS  = 4,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              single,
  input  logic              brdy,
  input  logic              backoff,
  input  logic              ahold,
  input  logic              hold,
  output logic              cyc,
  output logic [BEAT_W-1:0] beat,
  output logic              done,
  output logic              hlda
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic last;
  logic can_start;

  assign last      = single ? (beat == '0) : (beat == LAST_BEAT);
  assign can_start = req && !cyc && !backoff && !ahold && !hold && !hlda;
  assign done      = cyc && brdy && !backoff && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc  <= 1'b0;
      beat <= '0;
      hlda <= 1'b0;
    end else begin
      // Grant only between cycles.
      hlda <= hold && (hlda || !cyc);
      if (cyc) begin
        if (backoff) begin
          cyc  <= 1'b0;
          beat <= '0;
        end else if (brdy) begin
          if (last) begin
            cyc  <= 1'b0;
            beat <= '0;
          end else begin
            beat <= beat + 1'b1;
          end
        end
      end else if (can_start) begin
        cyc  <= 1'b1;
        beat <= '0;
      end
    end
  end

  a_r7_backoff_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && backoff) |=> !cyc);
  a_r8_grant_outside_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !cyc);
  a_r8_blocked_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc && (ahold || hold || backoff)) |=> !cyc);
endmodule

// File: rtl/flush_seq.sv
module flush_seq
  import flush_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int BEATS  = 4,
  parameter int ADDR_W = 29,
  localparam int LINES  = SETS * WAYS,
  localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_boundary,
  input  logic              flush_req,
  input  logic              wbinvd_req,
  input  logic              invd_req,
  input  logic              smi_req,
  output logic              smi_ack,
  output logic              pipe_flush,
  output logic              busy,
  output logic              done,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic              fill_icache,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic              fill_dirty,
  output logic [LINES-1:0]  dval_lin,
  output logic [LINES-1:0]  dval_phys,
  output logic [LINES-1:0]  ival_lin,
  output logic [LINES-1:0]  ival_phys,
  output logic              bus_cyc,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_be,
  output logic              bus_dc,
  output logic              bus_mio,
  output logic              bus_wr,
  input  logic              bus_brdy,
  input  logic              bus_backoff,
  input  logic              bus_ahold,
  input  logic              bus_hold,
  output logic              bus_hlda
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  seq_state_t        state;
  flush_kind_t       kind_q;
  flush_kind_t       arb_kind;
  logic [IDX_W-1:0]  idx;
  logic [LINES-1:0]  dirty;
  logic              idle;
  logic              start;
  logic              eng_done;
  logic [BEAT_W-1:0] eng_beat;
  logic              line_needs_wb;

  assign idle       = (state == S_IDLE);
  assign busy       = !idle;
  assign done       = (state == S_DONE);
  assign pipe_flush = (state == S_PIPE);
  assign fill_ready = idle;

  flush_req_arb u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .idle          (idle),
    .insn_boundary (insn_boundary),
    .flush_req     (flush_req),
    .wbinvd_req    (wbinvd_req),
    .invd_req      (invd_req),
    .smi_req       (smi_req),
    .start         (start),
    .kind          (arb_kind),
    .smi_ack       (smi_ack)
  );

  flush_tag_store #(.LINES(LINES), .IDX_W(IDX_W)) u_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_en     (fill_valid && fill_ready),
    .fill_icache (fill_icache),
    .fill_idx    (fill_idx),
    .fill_dirty  (fill_dirty),
    .inval_all   (state == S_INVAL),
    .clean_en    ((state == S_WB) && eng_done),
    .clean_idx   (idx),
    .dval_lin    (dval_lin),
    .dval_phys   (dval_phys),
    .ival_lin    (ival_lin),
    .ival_phys   (ival_phys),
    .dirty       (dirty)
  );

  flush_bus_engine #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     ((state == S_WB) || (state == S_ACK)),
    .single  (state == S_ACK),
    .brdy    (bus_brdy),
    .backoff (bus_backoff),
    .ahold   (bus_ahold),
    .hold    (bus_hold),
    .cyc     (bus_cyc),
    .beat    (eng_beat),
    .done    (eng_done),
    .hlda    (bus_hlda)
  );

  assign line_needs_wb = dval_lin[idx] && dirty[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind_q <= K_FLUSH;
      idx    <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state  <= S_PIPE;
          kind_q <= arb_kind;
          idx    <= '0;
        end
        S_PIPE: begin
          idx   <= '0;
          state <= (kind_q == K_INVD) ? S_INVAL : S_SCAN;
        end
        S_SCAN: begin
          if (line_needs_wb)         state <= S_WB;
          else if (idx == LAST_IDX)  state <= S_INVAL;
          else                       idx   <= idx + 1'b1;
        end
        S_WB: if (eng_done) begin
          if (idx == LAST_IDX) state <= S_INVAL;
          else begin
            idx   <= idx + 1'b1;
            state <= S_SCAN;
          end
        end
        S_INVAL: state <= (kind_q == K_INVD) ? S_DONE : S_ACK;
        S_ACK:   if (eng_done) state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_addr = '0;
    bus_be   = '0;
    bus_dc   = 1'b0;
    bus_mio  = 1'b0;
    bus_wr   = 1'b0;
    if (bus_cyc && state == S_WB) begin
      bus_addr = ADDR_W'({idx, eng_beat});
      bus_be   = BE_LINE;
      bus_dc   = 1'b1;
      bus_mio  = 1'b1;
      bus_wr   = 1'b1;
    end else if (bus_cyc && state == S_ACK) begin
      bus_be = (kind_q == K_WBINVD) ? BE_WB_ACK : BE_FLUSH_ACK;
      bus_wr = 1'b1;
    end
  end

  a_r1_pipe_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pipe_flush && busy));
  a_r5_clean_before_inval: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INVAL && kind_q != K_INVD) |-> ((dirty & dval_lin) == '0));
  a_r6_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACK && bus_cyc && !bus_brdy && !bus_backoff) |=> bus_cyc);
  a_r10_invd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q == K_INVD) |-> !bus_cyc);
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

// File: tb/sim_flush_seq.sv
module sim_flush_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] kind;     // 0 flush, 1 wbinvd, 2 invd
    logic [7:0] vld;
    logic [7:0] drt;
    logic [7:0] imk;
    logic [3:0] nwb;
    logic [7:0] be;
    logic [3:0] bo;       // beat count at which backoff hits, F = none
    logic [1:0] blk;      // 0 none, 1 hold, 2 ahold
    logic [4:0] blk_at;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd0, 8'hFF, 8'h00, 8'h0F, 4'd0, 8'hEF, 4'hF, 2'd0, 5'd0},
    '{2'd0, 8'hFF, 8'h81, 8'hFF, 4'd2, 8'hEF, 4'hF, 2'd0, 5'd0},
    '{2'd0, 8'h5A, 8'h5A, 8'h01, 4'd4, 8'hEF, 4'd2, 2'd0, 5'd0},
    '{2'd1, 8'hFF, 8'h3C, 8'hF0, 4'd4, 8'hF7, 4'hF, 2'd1, 5'd4},
    '{2'd2, 8'hFF, 8'hFF, 8'hFF, 4'd0, 8'h00, 4'hF, 2'd0, 5'd0},
    '{2'd0, 8'hFF, 8'hFF, 8'h80, 4'd8, 8'hEF, 4'd5, 2'd2, 5'd3},
    '{2'd1, 8'h0F, 8'h01, 8'h00, 4'd1, 8'hF7, 4'd0, 2'd1, 5'd10}
  };

  logic clk = 0, rst_n = 0;
  logic insn_boundary = 0, flush_req = 0, wbinvd_req = 0, invd_req = 0, smi_req = 0;
  logic smi_ack, pipe_flush, busy, done;
  logic fill_valid = 0, fill_icache = 0, fill_dirty = 0;
  logic [2:0] fill_idx = 0;
  logic fill_ready;
  logic [7:0] dval_lin, dval_phys, ival_lin, ival_phys;
  logic bus_cyc, bus_dc, bus_mio, bus_wr, bus_hlda;
  logic [28:0] bus_addr;
  logic [7:0] bus_be;
  logic bus_brdy = 0, bus_backoff = 0, bus_ahold = 0, bus_hold = 0;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  bit poke = 0, smi_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flush_seq u0 (.*);

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int nxt(input logic [7:0] m, input int from);
    for (int i = from; i < 8; i++) if (m[i]) return i;
    return 8;
  endfunction

  task automatic fill_line(input bit ic, input int idx, input bit d);
    fill_valid = 1; fill_icache = ic; fill_idx = 3'(idx); fill_dirty = d;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic all_clear(input string rq);
    chk((dval_lin | dval_phys | ival_lin | ival_phys) == 8'h00, rq,
        {dval_lin, dval_phys, ival_lin, ival_phys}, 0);
  endtask

  task automatic run_op(input vec_t v);
    int line, beat, wb_cnt, beats_given, ack_wait;
    bit bo_used, ack_seen, hlda_seen, any_cyc, done_seen;
    logic prev_cyc, prev_blk;
    logic [7:0] m;
    m = v.drt & v.vld;
    for (int i = 0; i < 8; i++) begin
      if (v.vld[i]) fill_line(0, i, m[i]);
      if (v.imk[i]) fill_line(1, i, 0);
    end
    chk(dval_lin == v.vld && dval_phys == v.vld && ival_lin == v.imk, "R13", dval_lin, v.vld);
    insn_boundary = 1;
    flush_req = (v.kind == 0); wbinvd_req = (v.kind == 1); invd_req = (v.kind == 2);
    smi_req = smi_flag;
    #1;
    if (smi_flag) chk(smi_ack == 0, "R3", smi_ack, 0);
    @(negedge clk);
    flush_req = 0; wbinvd_req = 0; invd_req = 0;
    chk(pipe_flush && busy, "R1", {pipe_flush, busy}, 2'b11);
    chk(fill_ready == 0, "R13", fill_ready, 0);
    line = nxt(m, 0); beat = 0; wb_cnt = 0; beats_given = 0; ack_wait = 0;
    bo_used = 0; ack_seen = 0; hlda_seen = 0; any_cyc = 0; done_seen = 0;
    prev_cyc = 0; prev_blk = 0;
    for (int it = 0; it < 400; it++) begin
      if (!prev_cyc && bus_cyc && prev_blk) chk(0, "R8", bus_cyc, 0);
      if (bus_hlda && bus_cyc) chk(0, "R8", {bus_hlda, bus_cyc}, 2'b10);
      hlda_seen |= bus_hlda;
      any_cyc |= bus_cyc;
      bus_brdy = 0; bus_backoff = 0; bus_hold = 0; bus_ahold = 0;
      if (bus_cyc && bus_dc) begin
        chk(bus_addr == 29'(line * 4 + beat), "R4", bus_addr, line * 4 + beat);
        chk(bus_be == 8'hFF && bus_mio && bus_wr, "R4", {bus_be, bus_mio, bus_wr}, 10'h3FF);
        chk(dval_lin == v.vld && ival_lin == v.imk && dval_phys == v.vld, "R5", dval_lin, v.vld);
        if (v.bo == 4'(beats_given) && !bo_used) begin
          bus_backoff = 1; bo_used = 1; beat = 0;   // R7 reissue from beat 0
        end else begin
          bus_brdy = 1; beats_given++; beat++;
          if (beat == 4) begin beat = 0; wb_cnt++; line = nxt(m, line + 1); end
        end
      end else if (bus_cyc) begin
        ack_seen = 1;
        all_clear("R5");
        chk(bus_be == v.be, (v.kind == 1) ? "R9" : "R6", bus_be, v.be);
        chk(bus_addr == 0 && !bus_mio && bus_wr, "R6", {bus_addr, bus_mio, bus_wr}, 1);
        if (ack_wait < 2) begin
          chk(!done, "R6", done, 0);
          ack_wait++;
        end else bus_brdy = 1;
      end
      if (done) begin done_seen = 1; break; end
      if (v.blk == 1 && it >= int'(v.blk_at) && it < int'(v.blk_at) + 6) bus_hold = 1;
      if (v.blk == 2 && it >= int'(v.blk_at) && it < int'(v.blk_at) + 6) bus_ahold = 1;
      prev_cyc = bus_cyc;
      prev_blk = bus_hold | bus_ahold | bus_backoff;
      flush_req = (poke && it == 3);
      @(negedge clk);
    end
    flush_req = 0;
    chk(done_seen, "R12", done_seen, 1);
    chk(wb_cnt == int'(v.nwb), "R4", wb_cnt, v.nwb);
    chk(ack_seen == (v.kind != 2), "R6", ack_seen, v.kind != 2);
    if (v.kind == 2) chk(!any_cyc, "R10", any_cyc, 0);
    if (v.blk == 1) chk(hlda_seen, "R8", hlda_seen, 1);
    if (v.bo != 4'hF) chk(bo_used, "R7", bo_used, 1);
    @(negedge clk);
    chk(!done && !busy, "R12", {done, busy}, 0);
    all_clear((v.kind == 2) ? "R10" : "R5");
    if (smi_flag) begin
      #1;
      chk(smi_ack == 1, "R3", smi_ack, 1);
      @(negedge clk);
      smi_req = 0;
    end
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        chk(!busy, "R2", busy, 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic finish_op(input string rq);
    bit seen = 0;
    for (int k = 0; k < 200; k++) begin
      bus_brdy = bus_cyc;
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    bus_brdy = 0;
    chk(seen, rq, seen, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !bus_cyc && !bus_hlda && !done, "R11", {busy, bus_cyc, bus_hlda}, 0);
    all_clear("R11");
    rst_n = 1;
    @(negedge clk);
    chk(fill_ready == 1, "R13", fill_ready, 1);

    foreach (VECS[i]) run_op(VECS[i]);

    // R1: request away from boundary stays pending
    insn_boundary = 0; flush_req = 1;
    @(negedge clk);
    flush_req = 0;
    for (int k = 0; k < 3; k++) begin
      chk(!busy, "R1", busy, 0);
      @(negedge clk);
    end
    insn_boundary = 1;
    @(negedge clk);
    chk(busy && pipe_flush, "R1", {busy, pipe_flush}, 2'b11);
    finish_op("R1");

    // R2: pulse during busy is dropped; R3: flush beats pending interrupt
    poke = 1; smi_flag = 1;
    run_op(VECS[1]);
    poke = 0; smi_flag = 0;

    // R11: reset mid-sequence
    fill_line(0, 2, 1); fill_line(0, 6, 1); fill_line(1, 3, 0);
    flush_req = 1;
    @(negedge clk);
    flush_req = 0;
    for (int k = 0; k < 6; k++) begin
      bus_brdy = bus_cyc;
      @(negedge clk);
    end
    bus_brdy = 0;
    rst_n = 0;
    @(negedge clk);
    chk(!busy && !bus_cyc, "R11", {busy, bus_cyc}, 0);
    all_clear("R11");
    rst_n = 1;
    @(negedge clk);
    chk(!busy && fill_ready, "R11", {busy, fill_ready}, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule